// File: doc/BRIEF.md
# Port-Programmed Debug Command Unit

This block sits on a simple I/O bus and lets software drive a memory-watch monitor through two 16-bit I/O locations. A command location takes magic values. One value arms the unit. Two values pick which of two 32-bit staging registers is loaded. One value hands the staged pair on as an address range. One value disarms the unit. A data location builds up the selected staging register 16 bits at a time: each write shifts the old contents up by a half word and places the new half word at the bottom.

When a range is committed, the block raises a one-cycle strobe that carries the start and end addresses to a range table, which lies outside this block. The armed state is available as a level output. It can also be read back through the command location. Every bus access must have a size of two bytes to have any effect. Data-port loads take effect whether or not the unit is armed. Commands other than arming are honoured only while the unit is armed.

Top module: `portcmd_ctl`

## Requirements
- R1: After reset the unit is disarmed, rangeValid is low, and a 2-byte read of the command location (0x8A00) returns 0.
- R2: Only accesses with ioSize equal to 2 at address 0x8A00 (command) or 0x8A01 (data) have any effect. Any other size or address changes no state.
- R3: A 2-byte write to 0x8A01 sets the selected staging register to (old value shifted left by 16) plus ioWrData[15:0]. This happens whether or not the unit is armed.
- R4: While disarmed, writing 0x8A00 to the command location arms the unit and clears both staging registers. Every other command value is ignored while disarmed. The command value is compared over the full 32-bit data word.
- R5: While armed, command 0x8A01 selects staging register 0 and command 0x8A02 selects staging register 1.
- R6: While armed, command 0x8A80 produces, one clock later, a single-cycle rangeValid pulse with rangeStart equal to register 0 and rangeEnd equal to register 1. It then clears both registers and selects register 0. rangeStart and rangeEnd hold their values between pulses.
- R7: While armed, command 0x8AFF disarms the unit. Any other unlisted command value, including 0x8A00, changes no state while armed.
- R8: A 2-byte read of 0x8A00 returns 0x00008A00 in the same cycle when the unit is armed, and 0 when it is disarmed. Reads of 0x8A01, reads of any other address, and reads of any other size return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | Bus write strobe, one cycle per access |
| ioRdEn | input | 1 | Bus read strobe |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 32 | Write data |
| ioSize | input | 3 | Access size in bytes |
| ioRdData | output | 32 | Read data, combinational |
| armed | output | 1 | Monitor armed level |
| rangeValid | output | 1 | One-cycle range commit strobe |
| rangeStart | output | 32 | Committed start address |
| rangeEnd | output | 32 | Committed end address |

## Verification
Every write lands on the clock edge that samples it. Because of that, armed, the staging registers and the rangeValid pulse together with rangeStart and rangeEnd are all visible one edge after the write. The bench drives each access at a falling edge and checks the outputs at the next falling edge. Read data is combinational, so read checks are sampled in the same cycle, a short delay after the read strobe is applied. The values of the staging registers are observed only through commits, so every load sequence in the bench ends with a commit.

// File: rtl/portcmd_pkg.sv
package portcmd_pkg;
  localparam logic [15:0] CMD_ARM    = 16'h8A00;
  localparam logic [15:0] CMD_SEL0   = 16'h8A01;
  localparam logic [15:0] CMD_SEL1   = 16'h8A02;
  localparam logic [15:0] CMD_COMMIT = 16'h8A80;
  localparam logic [15:0] CMD_DISARM = 16'h8AFF;
  localparam logic [15:0] ARMED_TOKEN = 16'h8A00;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearRegs;
    logic selLoad;
    logic selVal;
    logic shiftIn;
    logic commit;
  } ctlStrobes_t;
endpackage

// File: rtl/portcmd_ctrl.sv
module portcmd_ctrl
  import portcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h8A00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h8A01,
  parameter int ACCESS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic [SIZE_W-1:0] ioSize,
  output logic [DATA_W-1:0] ioRdData,
  output logic              armed,
  output ctlStrobes_t       stb
);
  localparam logic [SIZE_W-1:0] SIZE_OK = SIZE_W'(ACCESS_BYTES);

  logic sizeOk, cmdWr, dataWr, cmdRd;
  logic isArm, isSel0, isSel1, isCommit, isDisarm;
  logic armSet, armClr;

  assign sizeOk = (ioSize == SIZE_OK);
  assign cmdWr  = ioWrEn && sizeOk && (ioAddr == CMD_ADDR);
  assign dataWr = ioWrEn && sizeOk && (ioAddr == DATA_ADDR);
  assign cmdRd  = ioRdEn && sizeOk && (ioAddr == CMD_ADDR);

  assign isArm    = (ioWrData == DATA_W'(CMD_ARM));
  assign isSel0   = (ioWrData == DATA_W'(CMD_SEL0));
  assign isSel1   = (ioWrData == DATA_W'(CMD_SEL1));
  assign isCommit = (ioWrData == DATA_W'(CMD_COMMIT));
  assign isDisarm = (ioWrData == DATA_W'(CMD_DISARM));

  assign armSet = cmdWr && !armed && isArm;
  assign armClr = cmdWr && armed && isDisarm;

  always_comb begin
    stb           = '0;
    stb.shiftIn   = dataWr;
    stb.commit    = cmdWr && armed && isCommit;
    stb.clearRegs = armSet || stb.commit;
    stb.selLoad   = cmdWr && armed && (isSel0 || isSel1 || isCommit);
    stb.selVal    = isSel1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else if (armSet) armed <= 1'b1;
    else if (armClr) armed <= 1'b0;
  end

  assign ioRdData = (cmdRd && armed) ? DATA_W'(ARMED_TOKEN) : '0;
endmodule

// File: rtl/portcmd_dpath.sv
module portcmd_dpath
  import portcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DATA_W/2-1:0] wrHalf,
  output logic              rangeValid,
  output logic [DATA_W-1:0] rangeStart,
  output logic [DATA_W-1:0] rangeEnd
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NUM_REGS = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] valReg;
  logic selIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valReg <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (stb.clearRegs) valReg[i] <= '0;
        else if (stb.shiftIn && (selIdx == 1'(i)))
          valReg[i] <= {valReg[i][HALF_W-1:0], wrHalf};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) selIdx <= 1'b0;
    else if (stb.selLoad) selIdx <= stb.commit ? 1'b0 : stb.selVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeValid <= 1'b0;
      rangeStart <= '0;
      rangeEnd   <= '0;
    end else begin
      rangeValid <= stb.commit;
      if (stb.commit) begin
        rangeStart <= valReg[0];
        rangeEnd   <= valReg[1];
      end
    end
  end
endmodule

// File: rtl/portcmd_ctl.sv
module portcmd_ctl
  import portcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWrData,
  input  logic [SIZE_W-1:0] ioSize,
  output logic [DATA_W-1:0] ioRdData,
  output logic              armed,
  output logic              rangeValid,
  output logic [DATA_W-1:0] rangeStart,
  output logic [DATA_W-1:0] rangeEnd
);
  ctlStrobes_t stb;

  portcmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioSize(ioSize), .ioRdData(ioRdData), .armed(armed),
    .stb(stb)
  );

  portcmd_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrHalf(ioWrData[DATA_W/2-1:0]),
    .rangeValid(rangeValid), .rangeStart(rangeStart), .rangeEnd(rangeEnd)
  );
endmodule

// File: rtl/portcmd_chk.sv
module portcmd_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              ioWrEn,
  input logic              ioRdEn,
  input logic [ADDR_W-1:0] ioAddr,
  input logic [DATA_W-1:0] ioWrData,
  input logic [SIZE_W-1:0] ioSize,
  input logic [DATA_W-1:0] ioRdData,
  input logic              armed,
  input logic              rangeValid,
  input logic [DATA_W-1:0] rangeStart,
  input logic [DATA_W-1:0] rangeEnd
);
  logic cmdWr2;
  assign cmdWr2 = ioWrEn && (ioSize == SIZE_W'(2)) && (ioAddr == ADDR_W'(16'h8A00));

  AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rangeValid |-> $past(cmdWr2 && armed && ioWrData == DATA_W'(16'h8A80))); // R6
  AST_ARM_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(cmdWr2 && ioWrData == DATA_W'(16'h8A00))); // R4
  AST_DISARM_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> $past(cmdWr2 && ioWrData == DATA_W'(16'h8AFF))); // R7
  AST_WRONG_SIZE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioSize != SIZE_W'(2)) |=> ($stable(armed) && !rangeValid)); // R2
  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rangeValid |-> ($stable(rangeStart) && $stable(rangeEnd))); // R6
  AST_READ_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    (ioRdData != '0) |-> (armed && ioRdEn)); // R8
endmodule

bind portcmd_ctl portcmd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
  .ioWrData(ioWrData), .ioSize(ioSize), .ioRdData(ioRdData), .armed(armed),
  .rangeValid(rangeValid), .rangeStart(rangeStart), .rangeEnd(rangeEnd)
);

// File: tb/portcmd_ctl_tb.sv
module portcmd_ctl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [31:0] ioWrData = '0;
  logic [2:0]  ioSize = '0;
  logic [31:0] ioRdData, rangeStart, rangeEnd;
  logic armed, rangeValid;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  portcmd_ctl u_dut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioSize(ioSize), .ioRdData(ioRdData), .armed(armed),
    .rangeValid(rangeValid), .rangeStart(rangeStart), .rangeEnd(rangeEnd)
  );

  // Row: addr, size, data, expArmed, expValid, expStart, expEnd, requirement
  localparam int NV = 27;
  localparam logic [120:0] VEC [NV] = '{
    {16'h8A01, 3'd2, 32'h0000_1234, 1'b0, 1'b0, 32'h0, 32'h0, 4'd3}, // R3 disarmed load
    {16'h8A00, 3'd2, 32'h0000_8A80, 1'b0, 1'b0, 32'h0, 32'h0, 4'd4}, // R4 commit ignored
    {16'h8A00, 3'd4, 32'h0000_8A00, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2}, // R2 wrong size
    {16'h8A02, 3'd2, 32'h0000_8A00, 1'b0, 1'b0, 32'h0, 32'h0, 4'd2}, // R2 wrong address
    {16'h8A00, 3'd2, 32'h0001_8A00, 1'b0, 1'b0, 32'h0, 32'h0, 4'd4}, // R4 full-word compare
    {16'h8A00, 3'd2, 32'h0000_8A00, 1'b1, 1'b0, 32'h0, 32'h0, 4'd4}, // R4 arm
    {16'h8A01, 3'd2, 32'hAAAA_1111, 1'b1, 1'b0, 32'h0, 32'h0, 4'd3}, // R3
    {16'h8A01, 3'd2, 32'h0000_2222, 1'b1, 1'b0, 32'h0, 32'h0, 4'd3}, // R3
    {16'h8A00, 3'd2, 32'h0000_8A02, 1'b1, 1'b0, 32'h0, 32'h0, 4'd5}, // R5 sel1
    {16'h8A01, 3'd2, 32'h0000_3333, 1'b1, 1'b0, 32'h0, 32'h0, 4'd3}, // R3
    {16'h8A01, 3'd1, 32'h0000_4444, 1'b1, 1'b0, 32'h0, 32'h0, 4'd2}, // R2 byte write
    {16'h8A01, 3'd2, 32'h0000_5555, 1'b1, 1'b0, 32'h0, 32'h0, 4'd3}, // R3
    {16'h8A00, 3'd2, 32'h0000_8A80, 1'b1, 1'b1, 32'h1111_2222, 32'h3333_5555, 4'd6}, // R6
    {16'h8A01, 3'd2, 32'h0000_0007, 1'b1, 1'b0, 32'h1111_2222, 32'h3333_5555, 4'd6}, // R6 pulse ends, sel0
    {16'h8A00, 3'd2, 32'h0000_1234, 1'b1, 1'b0, 32'h1111_2222, 32'h3333_5555, 4'd7}, // R7 unknown
    {16'h8A00, 3'd2, 32'h0000_8A00, 1'b1, 1'b0, 32'h1111_2222, 32'h3333_5555, 4'd7}, // R7 arm while armed
    {16'h8A00, 3'd2, 32'h0000_8A80, 1'b1, 1'b1, 32'h0000_0007, 32'h0, 4'd6}, // R6 cleared regs
    {16'h8A00, 3'd2, 32'h0000_8AFF, 1'b0, 1'b0, 32'h0000_0007, 32'h0, 4'd7}, // R7 disarm
    {16'h8A01, 3'd2, 32'h0000_9999, 1'b0, 1'b0, 32'h0000_0007, 32'h0, 4'd3}, // R3 disarmed
    {16'h8A00, 3'd2, 32'h0000_8A02, 1'b0, 1'b0, 32'h0000_0007, 32'h0, 4'd4}, // R4 select ignored
    {16'h8A00, 3'd2, 32'h0000_8A00, 1'b1, 1'b0, 32'h0000_0007, 32'h0, 4'd4}, // R4 rearm clears
    {16'h8A00, 3'd2, 32'h0000_8A80, 1'b1, 1'b1, 32'h0, 32'h0, 4'd4}, // R4 regs were cleared
    {16'h8A00, 3'd2, 32'h0000_8A02, 1'b1, 1'b0, 32'h0, 32'h0, 4'd5}, // R5
    {16'h8A01, 3'd2, 32'h0000_00AB, 1'b1, 1'b0, 32'h0, 32'h0, 4'd5}, // R5
    {16'h8A00, 3'd2, 32'h0000_8A01, 1'b1, 1'b0, 32'h0, 32'h0, 4'd5}, // R5 sel0
    {16'h8A01, 3'd2, 32'h0000_00CD, 1'b1, 1'b0, 32'h0, 32'h0, 4'd5}, // R5
    {16'h8A00, 3'd2, 32'h0000_8A80, 1'b1, 1'b1, 32'h0000_00CD, 32'h0000_00AB, 4'd5}  // R5
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [2:0] s, input logic [31:0] d);
    ioWrEn = 1'b1; ioAddr = a; ioSize = s; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input logic [2:0] s, input logic [31:0] exp,
                        input string req);
    ioRdEn = 1'b1; ioAddr = a; ioSize = s;
    #1;
    check(ioRdData == exp, req, "read data", ioRdData, exp);
    @(negedge clk);
    ioRdEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(armed == 1'b0, "R1", "armed", 32'(armed), 32'h0);
    check(rangeValid == 1'b0, "R1", "rangeValid", 32'(rangeValid), 32'h0);
    doRead(16'h8A00, 3'd2, 32'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      string req;
      req = $sformatf("R%0d row%0d", VEC[i][3:0], i);
      doWrite(VEC[i][120:105], VEC[i][104:102], VEC[i][101:70]);
      check(armed == VEC[i][69], req, "armed", 32'(armed), 32'(VEC[i][69]));
      check(rangeValid == VEC[i][68], req, "rangeValid", 32'(rangeValid), 32'(VEC[i][68]));
      check(rangeStart == VEC[i][67:36], req, "rangeStart", rangeStart, VEC[i][67:36]);
      check(rangeEnd == VEC[i][35:4], req, "rangeEnd", rangeEnd, VEC[i][35:4]);
    end

    // R8 reads while armed
    doRead(16'h8A00, 3'd2, 32'h0000_8A00, "R8 armed");
    doRead(16'h8A01, 3'd2, 32'h0, "R8 data port");
    doRead(16'h8A00, 3'd4, 32'h0, "R8 size");
    doRead(16'h1234, 3'd2, 32'h0, "R8 address");
    // R6 single pulse: second commit back to back carries cleared regs
    doWrite(16'h8A00, 3'd2, 32'h0000_8A80);
    check(rangeValid == 1'b1 && rangeStart == 32'h0, "R6", "b2b start", rangeStart, 32'h0);
    @(negedge clk);
    check(rangeValid == 1'b0, "R6", "pulse width", 32'(rangeValid), 32'h0);
    // R7 disarm then R8 read returns zero
    doWrite(16'h8A00, 3'd2, 32'h0000_8AFF);
    check(armed == 1'b0, "R7", "armed", 32'(armed), 32'h0);
    doRead(16'h8A00, 3'd2, 32'h0, "R8 disarmed");
    // R1 reset mid-operation
    doWrite(16'h8A00, 3'd2, 32'h0000_8A00);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(armed == 1'b0, "R1", "armed after reset", 32'(armed), 32'h0);
    check(rangeStart == 32'h0, "R1", "rangeStart after reset", rangeStart, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule